// File: doc/BRIEF.md
# Stereo Sample Hub

The stereo sample hub links a processor bus to an audio codec's parallel sample ports. It holds four sample queues of equal depth: a left and a right capture queue, filled by the codec, and a left and a right playback queue, drained toward the codec. Software sees four 32-bit words, chosen by a two-bit word select. These are a control word, a packed occupancy word, and one data word per channel. Reading a data word takes the oldest captured sample of that channel. Writing a data word queues a sample for playback on that channel.

The codec side runs on a one-cycle sample strobe. On each strobe, a captured stereo pair, when offered, enters both capture queues together. On the same strobe, a playback pair leaves both playback queues together, but only when each of the two holds at least one sample. A single level-sensitive interrupt line asks software for service while a capture queue is nearly full or a playback queue is nearly empty. There is no acknowledge: the line falls only after software moves enough samples.

Top module: `stereo_sample_hub`

## Requirements
- R1: After reset, all four queues are empty, both interrupt enables are off, `irq`, `play_valid` and `cap_overrun` are low, the control word reads 0 and the occupancy word reads 0x80800000.
- R2: The word select chooses the register: 0 is control, 1 is occupancy, 2 is left data and 3 is right data.
- R3: A data-word write pushes `bus_wdata` into that channel's playback queue. A data-word read pops that channel's capture queue. Read data of any register appears on `bus_rdata` in the cycle after the cycle with `bus_rd` high, and it holds until the next read.
- R4: The occupancy word carries four byte fields. Bits 7:0 hold the samples waiting in the right capture queue, bits 15:8 those waiting in the left capture queue, bits 23:16 the free slots of the right playback queue, and bits 31:24 the free slots of the left playback queue.
- R5: A data read from an empty capture queue returns 0 and leaves the queue as it was. A data write to a full playback queue is dropped, and the samples already queued stay unchanged.
- R6: On a strobe with `cap_valid` high, the pair `cap_left`/`cap_right` is stored when neither capture queue is full. Otherwise both samples are discarded and `cap_overrun` goes high. `cap_overrun` stays high until a capture clear.
- R7: On a strobe, if both playback queues hold data, their oldest samples appear on `play_left`/`play_right` with `play_valid` high for one cycle, in the following cycle. If either queue is empty, nothing is sent and neither queue is popped.
- R8: The read condition holds while either capture queue holds at least 3/4 of its depth (96 of 128). The write condition holds while either playback queue holds at most 1/4 of its depth (32 of 128). Control bit 8 shows read condition AND read enable. Control bit 9 shows write condition AND write enable. `irq` is high while either of those bits is set.
- R9: Writing the control word sets the read enable from bit 0 and the write enable from bit 1, and both read back. A 1 in bit 2 empties both capture queues. A 1 in bit 3 empties both playback queues. Bits 2 and 3 always read back as 0.
- R10: No queue ever holds more samples than its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Word select: 0 control, 1 occupancy, 2 left data, 3 right data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| sample_tick | input | 1 | Codec sample-rate strobe, one cycle wide |
| cap_valid | input | 1 | A captured pair is offered on this strobe |
| cap_left | input | 32 | Captured left sample |
| cap_right | input | 32 | Captured right sample |
| play_valid | output | 1 | Playback pair valid, one cycle |
| play_left | output | 32 | Playback left sample |
| play_right | output | 32 | Playback right sample |
| cap_overrun | output | 1 | Sticky flag: a captured pair was dropped |
| irq | output | 1 | Level interrupt request |

## Verification
Every register read result is due on the falling edge after the rising edge that took `bus_rd`. Each queue occupancy, the occupancy word, `cap_overrun` and `irq` change at the rising edge that takes the write, read or strobe. A playback pair is due in the single cycle after its strobe. The bench drives each stimulus on a falling edge and samples at the next falling edge, so every check sees exactly one edge of effect. Its scoreboard decides at strobe time whether a pair must leave, so a missing pair, an extra pair and a wrong pair are all caught.

// File: rtl/shub_pkg.sv
`timescale 1ns/1ps
package shub_pkg;
  localparam int unsigned NUM_FIFO = 4;
  // queue slots; the two capture queues come first
  localparam int unsigned CAP_L  = 0;
  localparam int unsigned CAP_R  = 1;
  localparam int unsigned PLAY_L = 2;
  localparam int unsigned PLAY_R = 3;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_SPACE = 2'd1,
    SEL_LEFT  = 2'd2,
    SEL_RIGHT = 2'd3
  } reg_sel_e;

  // control word bit positions
  localparam int unsigned CB_RD_EN    = 0;
  localparam int unsigned CB_WR_EN    = 1;
  localparam int unsigned CB_CLR_CAP  = 2;
  localparam int unsigned CB_CLR_PLAY = 3;
  localparam int unsigned CB_RD_PEND  = 8;
  localparam int unsigned CB_WR_PEND  = 9;

  // capture side is crowded: at least three quarters occupied
  function automatic logic fill_hot(input int unsigned used, input int unsigned depth);
    return (used * 4) >= (depth * 3);
  endfunction

  // playback side is starving: at most one quarter occupied
  function automatic logic drain_hot(input int unsigned used, input int unsigned depth);
    return (used * 4) <= depth;
  endfunction

  function automatic logic [31:0] pack_space(input logic [7:0] avail_r, input logic [7:0] avail_l,
                                             input logic [7:0] room_r,  input logic [7:0] room_l);
    return {room_l, room_r, avail_l, avail_r};
  endfunction
endpackage

// File: rtl/shub_fifo.sv
`timescale 1ns/1ps
module shub_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     used,
  output logic              full,
  output logic              empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic              do_push;
  logic              do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (used == CW'(DEPTH));
  assign empty   = (used == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/shub_irq.sv
`timescale 1ns/1ps
module shub_irq
  import shub_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                       rd_en,
  input  logic                       wr_en,
  input  logic [NUM_FIFO-1:0][CW-1:0] used,
  output logic                       rd_cond,
  output logic                       wr_cond,
  output logic                       rd_pend,
  output logic                       wr_pend,
  output logic                       irq
);
  assign rd_cond = fill_hot(32'(used[CAP_L]), DEPTH) | fill_hot(32'(used[CAP_R]), DEPTH);
  assign wr_cond = drain_hot(32'(used[PLAY_L]), DEPTH) | drain_hot(32'(used[PLAY_R]), DEPTH);
  assign rd_pend = rd_cond & rd_en;
  assign wr_pend = wr_cond & wr_en;
  assign irq     = rd_pend | wr_pend;
endmodule

// File: rtl/stereo_sample_hub.sv
`timescale 1ns/1ps
module stereo_sample_hub
  import shub_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sample_tick,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_left,
  input  logic [DATA_W-1:0] cap_right,
  output logic              play_valid,
  output logic [DATA_W-1:0] play_left,
  output logic [DATA_W-1:0] play_right,
  output logic              cap_overrun,
  output logic              irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  reg_sel_e sel;
  logic     rd_en_q, wr_en_q;
  logic     ctrl_wr;
  logic     clr_cap, clr_play;
  logic     cap_accept, cap_drop, play_fire;
  logic     host_pop_l, host_pop_r, host_push_l, host_push_r;
  logic     rd_cond, wr_cond, rd_pend, wr_pend;

  logic [NUM_FIFO-1:0]             f_push, f_pop, f_clr, f_full, f_empty;
  logic [NUM_FIFO-1:0][DATA_W-1:0] f_wdata, f_head;
  logic [NUM_FIFO-1:0][CW-1:0]     f_used;

  logic [31:0] ctrl_word;
  logic [31:0] space_word;

  assign sel = reg_sel_e'(reg_sel);

  // host-side events
  assign ctrl_wr     = bus_wr && (sel == SEL_CTRL);
  assign clr_cap     = ctrl_wr & bus_wdata[CB_CLR_CAP];
  assign clr_play    = ctrl_wr & bus_wdata[CB_CLR_PLAY];
  assign host_pop_l  = bus_rd && (sel == SEL_LEFT)  && !f_empty[CAP_L];
  assign host_pop_r  = bus_rd && (sel == SEL_RIGHT) && !f_empty[CAP_R];
  assign host_push_l = bus_wr && (sel == SEL_LEFT)  && !f_full[PLAY_L];
  assign host_push_r = bus_wr && (sel == SEL_RIGHT) && !f_full[PLAY_R];

  // codec-side events: both channels move together or not at all
  assign cap_accept = sample_tick & cap_valid & ~f_full[CAP_L] & ~f_full[CAP_R];
  assign cap_drop   = sample_tick & cap_valid & (f_full[CAP_L] | f_full[CAP_R]);
  assign play_fire  = sample_tick & ~f_empty[PLAY_L] & ~f_empty[PLAY_R];

  always_comb begin
    f_push          = '0;
    f_pop           = '0;
    f_push[CAP_L]   = cap_accept;
    f_push[CAP_R]   = cap_accept;
    f_push[PLAY_L]  = host_push_l;
    f_push[PLAY_R]  = host_push_r;
    f_pop[CAP_L]    = host_pop_l;
    f_pop[CAP_R]    = host_pop_r;
    f_pop[PLAY_L]   = play_fire;
    f_pop[PLAY_R]   = play_fire;
    f_clr[CAP_L]    = clr_cap;
    f_clr[CAP_R]    = clr_cap;
    f_clr[PLAY_L]   = clr_play;
    f_clr[PLAY_R]   = clr_play;
    f_wdata[CAP_L]  = cap_left;
    f_wdata[CAP_R]  = cap_right;
    f_wdata[PLAY_L] = bus_wdata;
    f_wdata[PLAY_R] = bus_wdata;
  end

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
    shub_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (f_clr[g]),
      .push  (f_push[g]),
      .pop   (f_pop[g]),
      .wdata (f_wdata[g]),
      .head  (f_head[g]),
      .used  (f_used[g]),
      .full  (f_full[g]),
      .empty (f_empty[g])
    );
  end

  shub_irq #(.DEPTH(DEPTH), .CW(CW)) u_irq (
    .rd_en   (rd_en_q),
    .wr_en   (wr_en_q),
    .used    (f_used),
    .rd_cond (rd_cond),
    .wr_cond (wr_cond),
    .rd_pend (rd_pend),
    .wr_pend (wr_pend),
    .irq     (irq)
  );

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[CB_RD_EN]   = rd_en_q;
    ctrl_word[CB_WR_EN]   = wr_en_q;
    ctrl_word[CB_RD_PEND] = rd_pend;
    ctrl_word[CB_WR_PEND] = wr_pend;
  end

  assign space_word = pack_space(8'(f_used[CAP_R]), 8'(f_used[CAP_L]),
                                 8'(CW'(DEPTH) - f_used[PLAY_R]),
                                 8'(CW'(DEPTH) - f_used[PLAY_L]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
    end else if (ctrl_wr) begin
      rd_en_q <= bus_wdata[CB_RD_EN];
      wr_en_q <= bus_wdata[CB_WR_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_CTRL:  bus_rdata <= ctrl_word;
        SEL_SPACE: bus_rdata <= space_word;
        SEL_LEFT:  bus_rdata <= f_empty[CAP_L] ? '0 : 32'(f_head[CAP_L]);
        SEL_RIGHT: bus_rdata <= f_empty[CAP_R] ? '0 : 32'(f_head[CAP_R]);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_overrun <= 1'b0;
    else if (clr_cap)  cap_overrun <= 1'b0;
    else if (cap_drop) cap_overrun <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      play_valid <= 1'b0;
      play_left  <= '0;
      play_right <= '0;
    end else begin
      play_valid <= play_fire;
      if (play_fire) begin
        play_left  <= f_head[PLAY_L];
        play_right <= f_head[PLAY_R];
      end
    end
  end
endmodule

// File: rtl/shub_checker.sv
`timescale 1ns/1ps
module shub_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         reg_sel,
  input logic               bus_rd,
  input logic [31:0]        bus_rdata,
  input logic [3:0][CW-1:0] used,
  input logic               rd_en,
  input logic               wr_en,
  input logic               irq,
  input logic               clr_cap,
  input logic               clr_play,
  input logic               cap_drop,
  input logic               cap_overrun,
  input logic               sample_tick,
  input logic               play_valid
);
  for (genvar g = 0; g < 4; g++) begin : g_bound
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      32'(used[g]) <= DEPTH);
  end

  p_read_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ((32'(used[0]) * 4 >= DEPTH * 3) || (32'(used[1]) * 4 >= DEPTH * 3))) |-> irq);

  p_write_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((32'(used[2]) * 4 <= DEPTH) || (32'(used[3]) * 4 <= DEPTH))) |-> irq);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |-> !irq);

  p_clear_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cap |=> (used[0] == '0 && used[1] == '0));

  p_clear_play_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_play |=> (used[2] == '0 && used[3] == '0));

  p_pair_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && (used[2] == '0 || used[3] == '0)) |=> !play_valid);

  p_pair_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid |-> $past(sample_tick));

  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_drop && !clr_cap) |=> cap_overrun);

  p_overrun_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_overrun && !clr_cap) |=> cap_overrun);

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && reg_sel == 2'd2 && used[0] == '0) |=> (bus_rdata == '0));
endmodule

bind stereo_sample_hub shub_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_sel     (reg_sel),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .used        (f_used),
  .rd_en       (rd_en_q),
  .wr_en       (wr_en_q),
  .irq         (irq),
  .clr_cap     (clr_cap),
  .clr_play    (clr_play),
  .cap_drop    (cap_drop),
  .cap_overrun (cap_overrun),
  .sample_tick (sample_tick),
  .play_valid  (play_valid)
);

// File: tb/stereo_sample_hub_bench.sv
`timescale 1ns/1ps
module stereo_sample_hub_bench;
  localparam int unsigned DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sample_tick, cap_valid;
  logic [31:0] cap_left, cap_right;
  logic        play_valid;
  logic [31:0] play_left, play_right;
  logic        cap_overrun, irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] q_cap_l[$], q_cap_r[$], q_play_l[$], q_play_r[$];
  logic [31:0] q_out_l[$], q_out_r[$];

  always #2.5 clk = ~clk;

  stereo_sample_hub #(.DATA_W(32), .DEPTH(DEPTH)) u_stereo_sample_hub (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_tick(sample_tick),
    .cap_valid(cap_valid), .cap_left(cap_left), .cap_right(cap_right),
    .play_valid(play_valid), .play_left(play_left), .play_right(play_right),
    .cap_overrun(cap_overrun), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [31:0] data);
    reg_sel = sel; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] sel, output logic [31:0] data);
    reg_sel = sel; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = bus_rdata;
  endtask

  // driver side of the scoreboard: playback writes
  task automatic push_left(input logic [31:0] v);
    if (q_play_l.size() < DEPTH) q_play_l.push_back(v);
    bus_write(2'd2, v);
  endtask

  task automatic push_right(input logic [31:0] v);
    if (q_play_r.size() < DEPTH) q_play_r.push_back(v);
    bus_write(2'd3, v);
  endtask

  // strobe; the expected pair moves to the output queue only when both sides hold data
  task automatic strobe(input logic with_cap, input logic [31:0] l, input logic [31:0] r);
    if (q_play_l.size() > 0 && q_play_r.size() > 0) begin
      q_out_l.push_back(q_play_l.pop_front());
      q_out_r.push_back(q_play_r.pop_front());
    end
    if (with_cap && q_cap_l.size() < DEPTH && q_cap_r.size() < DEPTH) begin
      q_cap_l.push_back(l);
      q_cap_r.push_back(r);
    end
    cap_left = l; cap_right = r; cap_valid = with_cap; sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0; cap_valid = 1'b0;
  endtask

  task automatic read_data(input logic right, input string tag);
    logic [31:0] d, e;
    if (right) e = (q_cap_r.size() > 0) ? q_cap_r.pop_front() : 32'h0;
    else       e = (q_cap_l.size() > 0) ? q_cap_l.pop_front() : 32'h0;
    bus_read(right ? 2'd3 : 2'd2, d);
    check(tag, d, e);
  endtask

  task automatic expect_reg(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_read(sel, d);
    check(tag, d, exp);
  endtask

  // monitor side of the scoreboard (R7)
  always @(negedge clk) begin
    if (rst_n && play_valid) begin
      if (q_out_l.size() == 0) begin
        check("R7 unexpected playback pair", 32'h1, 32'h0);
      end else begin
        check("R7 playback left", play_left, q_out_l.pop_front());
        check("R7 playback right", play_right, q_out_r.pop_front());
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    sample_tick = 1'b0; cap_valid = 1'b0; cap_left = '0; cap_right = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 register select
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 overrun after reset", {31'b0, cap_overrun}, 32'h0);
    check("R1 play_valid after reset", {31'b0, play_valid}, 32'h0);
    expect_reg(2'd0, 32'h0, "R1 R2 control word after reset");
    expect_reg(2'd1, 32'h8080_0000, "R1 R2 occupancy word after reset");

    // R9 enable readback, R8 write condition on empty playback
    bus_write(2'd0, 32'h2);
    check("R8 write irq on empty playback", {31'b0, irq}, 32'h1);
    expect_reg(2'd0, 32'h0000_0202, "R9 R8 control readback");

    // R3 R4 playback pushes
    for (int i = 0; i < 40; i++) begin
      push_left(32'h1000_0000 + 32'(i));
      push_right(32'hF000_0000 - 32'(i));
    end
    expect_reg(2'd1, 32'h5858_0000, "R4 occupancy after 40 pairs");
    check("R8 irq off at 40 queued", {31'b0, irq}, 32'h0);

    // R7 playback drain down to the threshold
    for (int i = 0; i < 7; i++) strobe(1'b0, '0, '0);
    check("R8 irq off at 33 queued", {31'b0, irq}, 32'h0);
    strobe(1'b0, '0, '0);
    check("R8 irq on at 32 queued", {31'b0, irq}, 32'h1);

    // R9 playback clear keeps the enable
    bus_write(2'd0, 32'hA);
    q_play_l.delete(); q_play_r.delete();
    expect_reg(2'd0, 32'h0000_0202, "R9 clear bit reads zero");
    expect_reg(2'd1, 32'h8080_0000, "R9 playback cleared");

    // R7 gating: left only holds data
    push_left(32'h0000_0055);
    strobe(1'b0, '0, '0);
    expect_reg(2'd1, 32'h7F80_0000, "R7 lone channel not popped");

    // R5 R10 full playback write dropped
    for (int i = 0; i < 127; i++) push_left(32'h2000_0000 + 32'(i));
    expect_reg(2'd1, 32'h0080_0000, "R10 left playback full");
    push_left(32'hDEAD_BEEF);
    expect_reg(2'd1, 32'h0080_0000, "R5 R10 write to full ignored");
    push_right(32'h0000_0077);
    strobe(1'b0, '0, '0);
    @(negedge clk);
    check("R7 pair delivered", {31'b0, (q_out_l.size() == 0)}, 32'h1);
    bus_write(2'd0, 32'h8);
    q_play_l.delete(); q_play_r.delete();

    // R6 R8 capture path with read interrupt
    bus_write(2'd0, 32'h1);
    for (int i = 0; i < 95; i++) strobe(1'b1, 32'h3000_0000 + 32'(i), 32'h8000_0000 + 32'(i));
    check("R8 read irq off at 95", {31'b0, irq}, 32'h0);
    strobe(1'b1, 32'h3000_005F, 32'h8000_005F);
    check("R8 read irq on at 96", {31'b0, irq}, 32'h1);
    expect_reg(2'd0, 32'h0000_0101, "R8 read pending bit");
    expect_reg(2'd1, 32'h8080_6060, "R4 R6 capture occupancy");
    read_data(1'b0, "R3 left capture pop");
    read_data(1'b1, "R3 right capture pop");
    check("R8 read irq off after pops", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 33; i++) strobe(1'b1, 32'h4000_0000 + 32'(i), 32'h9000_0000 + 32'(i));
    expect_reg(2'd1, 32'h8080_8080, "R10 capture full");
    check("R6 no overrun yet", {31'b0, cap_overrun}, 32'h0);
    strobe(1'b1, 32'hAAAA_AAAA, 32'hBBBB_BBBB);
    check("R6 overrun set on drop", {31'b0, cap_overrun}, 32'h1);
    read_data(1'b0, "R3 left pop after drop");
    strobe(1'b1, 32'hCCCC_CCCC, 32'hDDDD_DDDD);
    expect_reg(2'd1, 32'h8080_7F80, "R6 pair dropped when one side full");
    check("R6 overrun sticky", {31'b0, cap_overrun}, 32'h1);
    read_data(1'b1, "R3 right order after drops");

    // R9 capture clear, R5 empty read
    bus_write(2'd0, 32'h5);
    q_cap_l.delete(); q_cap_r.delete();
    check("R9 overrun cleared", {31'b0, cap_overrun}, 32'h0);
    check("R9 irq off after clear", {31'b0, irq}, 32'h0);
    expect_reg(2'd1, 32'h8080_0000, "R9 capture cleared");
    read_data(1'b0, "R5 empty read returns zero");
    expect_reg(2'd1, 32'h8080_0000, "R5 empty read leaves queue");

    check("R7 no missing pairs", 32'(q_out_l.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule